// File: doc/BRIEF.md
# Multiformat Audio Serial Transmitter (I2S / Left-Justified / TDM)

This block turns parallel audio samples into one serial data stream. It drives the bit clock, the frame-sync (word-select) line and the data line itself. The frame can be two-channel I2S, two-channel left-justified, multi-slot TDM with the MSB delayed by one bit, or multi-slot TDM with the MSB not delayed. The block does not divide clocks. A one-cycle step pulse from outside toggles the bit clock once per pulse. Every falling bit-clock edge moves the serializer forward by one bit position.

Each channel has a 32-bit sample word with a valid flag. When the serializer reaches the first bit of a slot, it fetches the word for that slot's channel and then pulses one of two per-channel flags. The accept flag means a valid sample was taken. The underrun flag means no valid sample was present and a fill value was sent in its place. The fill value is either zero or the last sample that channel accepted. In mono mode, each odd slot repeats the word sent in the even slot before it. Configuration inputs must stay constant while the block is enabled.

Top module: `i2s_tdm_tx`

## Requirements
- R1: While `rst_n` is low, `sck_o`, `fs_o`, `sd_o`, `smp_ack_o` and `unf_o` are all 0.
- R2: With `en_i` high, each `tick_i` pulse toggles `sck_o`, and `sd_o`/`fs_o` change only in the cycle where `sck_o` falls. In format 0 (I2S), a frame has a left slot then a right slot. `fs_o` is 0 for the left slot and 1 for the right slot. The MSB of each slot appears one bit clock after the `fs_o` edge.
- R3: In format 1 (left-justified), `fs_o` is 1 for the left slot and 0 for the right slot. The MSB appears on the same falling edge as the `fs_o` change.
- R4: The sample-length code sets the number of bits sent: 0=32, 1=24, 2=20, 3=18, 4=16, 6=8. These bits are taken from the low end of the channel word. They are sent MSB first, starting at the first bit of the slot, and the rest of the slot is 0. In formats 0 and 1 the slot is 32 bits for code 0, 16 bits for code 4 and 8 bits for code 6.
- R5: For length codes 1, 2 and 3, `cfg_slot24_i`=0 gives a 32-bit slot and `cfg_slot24_i`=1 gives a 24-bit slot in formats 0 and 1.
- R6: In format 2 (TDM), the frame is (`cfg_chans_m1_i`+1)×32 bit clocks long. Slot k carries channel k. `fs_o` rises at the start of the frame and each slot's MSB follows one bit clock after its slot boundary. Sync-width code 0 holds `fs_o` high for the first 32 bit clocks.
- R7: In TDM formats, sync-width code 1 holds `fs_o` high for the first half of the frame. Codes 2 and 3 hold it high for only the first bit clock.
- R8: Format 3 (TDM left-justified) is format 2 without the delay: each slot's MSB appears on the slot's first bit clock, together with the `fs_o` rise at the start of the frame.
- R9: With `cfg_mono_i`=1, every odd slot repeats exactly the word sent in the even slot before it, and no odd channel is ever fetched, accepted or flagged.
- R10: A slot whose channel has `smp_valid_i` low sends zeros when `cfg_hold_i`=0 and pulses that channel's `unf_o`. `smp_ack_o` and `unf_o` are never high together.
- R11: With `cfg_hold_i`=1, an underrun slot repeats the last sample that channel accepted (0 if it has accepted none since reset), using the current length code.
- R12: Each fetch of a valid sample pulses exactly one `smp_ack_o` bit (that channel's) for one cycle. The pulse comes in the cycle where `sck_o` falls and the slot's first bit goes out.
- R13: Compact length codes 5 and 7 are sent exactly like codes 4 and 6.
- R14: While `en_i` is low, `sck_o`, `fs_o` and `sd_o` are 0 and stay 0 even if `tick_i` pulses. After `en_i` rises again, the next frame starts at bit position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the serializer idle |
| tick_i | input | 1 | Step pulse; each pulse toggles the bit clock |
| cfg_fmt_i | input | 2 | Frame format: 0 I2S, 1 left-justified, 2 TDM, 3 TDM left-justified |
| cfg_len_i | input | 3 | Sample-length code |
| cfg_slot24_i | input | 1 | 24-bit slot for length codes 1 to 3 in two-channel formats |
| cfg_chans_m1_i | input | CW | TDM slot count minus one |
| cfg_fsw_i | input | 2 | TDM frame-sync width code |
| cfg_mono_i | input | 1 | Odd slots repeat the preceding even slot |
| cfg_hold_i | input | 1 | Underrun fill: 0 zero, 1 last accepted sample |
| smp_data_i | input | MAX_CH*32 | Channel sample words, channel k in bits [32k+31:32k] |
| smp_valid_i | input | MAX_CH | Per-channel sample-present flags |
| smp_ack_o | output | MAX_CH | Per-channel accept pulse |
| unf_o | output | MAX_CH | Per-channel underrun pulse |
| sck_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync / word select |
| sd_o | output | 1 | Serial data |

## Verification
The most delicate collision is mono duplication meeting an underrun on the even channel. The odd slot must copy the fill word chosen for the even slot in that same frame, not fetch or flag anything itself. The bench provokes this by running mono I2S with channel 0 held invalid and hold-previous selected. It then compares the serial stream bit by bit against a model that builds each odd slot from the even slot's fill. It also checks that no accept or underrun pulse appears on channel 1. A second collision, in the delayed formats, is the frame-sync edge landing on the same bit clock as the last bit of the previous frame. Bit-exact comparison over back-to-back frames checks this.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LJ    = 2'd1,
    FMT_TDM   = 2'd2,
    FMT_TDMLJ = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    FSW_SLOT = 2'd0,
    FSW_HALF = 2'd1,
    FSW_BIT  = 2'd2,
    FSW_BIT2 = 2'd3
  } fsw_e;

  // number of data bits carried for a length code
  function automatic logic [5:0] len_bits(input logic [2:0] code);
    case (code)
      3'd0:       return 6'd32;
      3'd1:       return 6'd24;
      3'd2:       return 6'd20;
      3'd3:       return 6'd18;
      3'd4, 3'd5: return 6'd16;
      default:    return 6'd8;
    endcase
  endfunction

  // slot width of the two-channel formats
  function automatic logic [5:0] pair_slot(input logic [2:0] code, input logic s24);
    case (code)
      3'd0:             return 6'd32;
      3'd1, 3'd2, 3'd3: return s24 ? 6'd24 : 6'd32;
      3'd4, 3'd5:       return 6'd16;
      default:          return 6'd8;
    endcase
  endfunction

  // low-aligned sample moved to the MSB end, low bits cleared
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] raw,
                                                  input logic [2:0] code);
    return raw << (6'd32 - len_bits(code));
  endfunction

endpackage

// File: rtl/i2stx_timing.sv
module i2stx_timing
  import i2stx_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int CW  = $clog2(MAX_CH),
  localparam int PW  = $clog2(MAX_CH * WORD_W),
  localparam int FLW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [1:0]    fmt_i,
  input  logic [2:0]    len_i,
  input  logic          slot24_i,
  input  logic [CW-1:0] chans_m1_i,
  input  logic [1:0]    fsw_i,
  output logic          sck_o,
  output logic          fs_o,
  output logic          fall_o,
  output logic          load_o,
  output logic [CW-1:0] slot_o
);

  logic           sck_q, sck_d;
  logic           run_q, run_d;
  logic           fs_q, fs_d;
  logic [FLW-1:0] pos_q, pos_d;

  logic           tdm, dly, fall, start;
  logic [FLW-1:0] slot_w, flen, pos_n, dpos;
  logic [CW-1:0]  slot_n;
  logic           fs_n;

  always_comb begin
    tdm    = fmt_i[1];
    dly    = ~fmt_i[0];
    slot_w = tdm ? FLW'(WORD_W) : FLW'(pair_slot(len_i, slot24_i));
    flen   = tdm ? ((FLW'(chans_m1_i) + FLW'(1)) << 5) : (slot_w << 1);
    fall   = en_i & tick_i & sck_q;

    if (!run_q || pos_q == flen - FLW'(1)) pos_n = '0;
    else                                   pos_n = pos_q + FLW'(1);

    // data position lags the bit position by one in the delayed formats
    if (dly) dpos = (pos_n == '0) ? flen - FLW'(1) : pos_n - FLW'(1);
    else     dpos = pos_n;

    if (tdm) begin
      slot_n = dpos[PW-1:5];
      start  = (dpos[4:0] == 5'd0);
    end else begin
      slot_n = (dpos >= slot_w) ? CW'(1) : '0;
      start  = (dpos == '0) || (dpos == slot_w);
    end

    case (fmt_e'(fmt_i))
      FMT_I2S: fs_n = (pos_n >= slot_w);
      FMT_LJ:  fs_n = (pos_n < slot_w);
      default: begin
        case (fsw_e'(fsw_i))
          FSW_SLOT: fs_n = (pos_n < FLW'(WORD_W));
          FSW_HALF: fs_n = (pos_n < (flen >> 1));
          default:  fs_n = (pos_n == '0);
        endcase
      end
    endcase
  end

  always_comb begin
    sck_d = sck_q;
    run_d = run_q;
    pos_d = pos_q;
    fs_d  = fs_q;
    if (!en_i) begin
      sck_d = 1'b0;
      run_d = 1'b0;
      pos_d = '0;
      fs_d  = 1'b0;
    end else if (tick_i) begin
      sck_d = ~sck_q;
      if (sck_q) begin
        run_d = 1'b1;
        pos_d = pos_n;
        fs_d  = fs_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      run_q <= 1'b0;
      pos_q <= '0;
      fs_q  <= 1'b0;
    end else begin
      sck_q <= sck_d;
      run_q <= run_d;
      pos_q <= pos_d;
      fs_q  <= fs_d;
    end
  end

  assign sck_o  = sck_q;
  assign fs_o   = fs_q;
  assign fall_o = fall;
  assign load_o = fall & start;
  assign slot_o = slot_n;

  // R2
  sck_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> $stable(sck_o));

  // R14
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sck_o && !fs_o));

endmodule

// File: rtl/i2stx_fetch.sv
module i2stx_fetch
  import i2stx_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int CW = $clog2(MAX_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [CW-1:0]            slot_i,
  input  logic                     mono_i,
  input  logic                     hold_i,
  input  logic [2:0]               len_i,
  input  logic [MAX_CH*WORD_W-1:0] data_i,
  input  logic [MAX_CH-1:0]        valid_i,
  output logic [WORD_W-1:0]        word_o,
  output logic [MAX_CH-1:0]        ack_o,
  output logic [MAX_CH-1:0]        unf_o
);

  logic [WORD_W-1:0] prev_q [MAX_CH];
  logic [WORD_W-1:0] last_q, last_d;
  logic [MAX_CH-1:0] ack_q, ack_d, unf_q, unf_d;

  logic              copy, sel_valid, take, miss;
  logic [WORD_W-1:0] sel_data, fill, word;
  logic [MAX_CH-1:0] onehot;

  always_comb begin
    copy      = mono_i & slot_i[0];
    sel_valid = valid_i[slot_i];
    sel_data  = data_i[WORD_W*int'(slot_i) +: WORD_W];
    fill      = hold_i ? prev_q[slot_i] : '0;
    word      = copy ? last_q : align_msb(sel_valid ? sel_data : fill, len_i);
    take      = load_i & ~copy & sel_valid;
    miss      = load_i & ~copy & ~sel_valid;
    onehot    = MAX_CH'(1) << slot_i;
    ack_d     = take ? onehot : '0;
    unf_d     = miss ? onehot : '0;
    last_d    = load_i ? word : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      ack_q  <= '0;
      unf_q  <= '0;
    end else begin
      last_q <= last_d;
      ack_q  <= ack_d;
      unf_q  <= unf_d;
    end
  end

  for (genvar k = 0; k < MAX_CH; k++) begin : g_prev
    logic prev_en;
    assign prev_en = ack_d[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q[k] <= '0;
      else if (prev_en) prev_q[k] <= data_i[WORD_W*k +: WORD_W];
    end
  end

  assign word_o = word;
  assign ack_o  = ack_q;
  assign unf_o  = unf_q;

  // R12
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  // R10
  ack_unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o & unf_o) == '0);

  // R9
  mono_odd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mono_i && slot_i[0]) |=> (ack_o == '0 && unf_o == '0));

endmodule

// File: rtl/i2stx_shift.sv
module i2stx_shift
  import i2stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sd_o
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sd_q, sd_d;

  always_comb begin
    sh_d = sh_q;
    sd_d = sd_q;
    if (!en_i) begin
      sh_d = '0;
      sd_d = 1'b0;
    end else if (fall_i) begin
      if (load_i) begin
        sd_d = word_i[WORD_W-1];
        sh_d = {word_i[WORD_W-2:0], 1'b0};
      end else begin
        sd_d = sh_q[WORD_W-1];
        sh_d = {sh_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      sd_q <= sd_d;
    end
  end

  assign sd_o = sd_q;

  // R2
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !fall_i) |=> $stable(sd_o));

endmodule

// File: rtl/i2s_tdm_tx.sv
module i2s_tdm_tx
  import i2stx_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int CW = $clog2(MAX_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     tick_i,
  input  logic [1:0]               cfg_fmt_i,
  input  logic [2:0]               cfg_len_i,
  input  logic                     cfg_slot24_i,
  input  logic [CW-1:0]            cfg_chans_m1_i,
  input  logic [1:0]               cfg_fsw_i,
  input  logic                     cfg_mono_i,
  input  logic                     cfg_hold_i,
  input  logic [MAX_CH*WORD_W-1:0] smp_data_i,
  input  logic [MAX_CH-1:0]        smp_valid_i,
  output logic [MAX_CH-1:0]        smp_ack_o,
  output logic [MAX_CH-1:0]        unf_o,
  output logic                     sck_o,
  output logic                     fs_o,
  output logic                     sd_o
);

  logic              fall, load;
  logic [CW-1:0]     slot;
  logic [WORD_W-1:0] word;

  i2stx_timing #(.MAX_CH(MAX_CH)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .tick_i     (tick_i),
    .fmt_i      (cfg_fmt_i),
    .len_i      (cfg_len_i),
    .slot24_i   (cfg_slot24_i),
    .chans_m1_i (cfg_chans_m1_i),
    .fsw_i      (cfg_fsw_i),
    .sck_o      (sck_o),
    .fs_o       (fs_o),
    .fall_o     (fall),
    .load_o     (load),
    .slot_o     (slot)
  );

  i2stx_fetch #(.MAX_CH(MAX_CH)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .slot_i  (slot),
    .mono_i  (cfg_mono_i),
    .hold_i  (cfg_hold_i),
    .len_i   (cfg_len_i),
    .data_i  (smp_data_i),
    .valid_i (smp_valid_i),
    .word_o  (word),
    .ack_o   (smp_ack_o),
    .unf_o   (unf_o)
  );

  i2stx_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .fall_i (fall),
    .load_i (load),
    .word_i (word),
    .sd_o   (sd_o)
  );

  // R12
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|smp_ack_o) || (|unf_o)) |-> !sck_o);

endmodule

// File: tb/i2s_tdm_tx_tb.sv
module i2s_tdm_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int MAXB = 1024;

  logic             clk;
  logic             rst_n, en, tick;
  logic [1:0]       cfg_fmt, cfg_fsw;
  logic [2:0]       cfg_len, cfg_chm1;
  logic             cfg_slot24, cfg_mono, cfg_hold;
  logic [NCH*32-1:0] sdata;
  logic [NCH-1:0]   svalid, ack, unf;
  logic             sck, fs, sd;

  int checks = 0;
  int failures = 0;
  int src_cnt [NCH];
  int mdl_cnt [NCH];
  logic [31:0] mdl_prev [NCH];
  int exp_ack [NCH], exp_unf [NCH], got_ack [NCH], got_unf [NCH];
  logic exp_sd [MAXB], exp_fs [MAXB], got_sd [MAXB], got_fs [MAXB];
  logic [31:0] wds [64];

  i2s_tdm_tx #(.MAX_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick),
    .cfg_fmt_i(cfg_fmt), .cfg_len_i(cfg_len), .cfg_slot24_i(cfg_slot24),
    .cfg_chans_m1_i(cfg_chm1), .cfg_fsw_i(cfg_fsw), .cfg_mono_i(cfg_mono),
    .cfg_hold_i(cfg_hold), .smp_data_i(sdata), .smp_valid_i(svalid),
    .smp_ack_o(ack), .unf_o(unf), .sck_o(sck), .fs_o(fs), .sd_o(sd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] gen(input int k, input int n);
    return (32'h9E3779B9 * 32'(k*64 + n + 1)) ^ 32'(k << 28);
  endfunction

  function automatic int blen(input logic [2:0] c);
    case (c)
      3'd0: return 32;
      3'd1: return 24;
      3'd2: return 20;
      3'd3: return 18;
      3'd4, 3'd5: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic int pslot(input logic [2:0] c, input logic s24);
    case (c)
      3'd0: return 32;
      3'd1, 3'd2, 3'd3: return s24 ? 24 : 32;
      3'd4, 3'd5: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic bitof(input int f, input int d, input int sw);
    logic [31:0] w;
    w = wds[f*8 + d/sw];
    return w[31 - (d % sw)];
  endfunction

  task automatic refresh();
    for (int k = 0; k < NCH; k++) sdata[k*32 +: 32] = gen(k, src_cnt[k]);
  endtask

  task automatic check(input string tag, input string what, input logic ok,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic setcfg(input logic [1:0] f, input logic [2:0] l, input logic s24,
                        input logic [2:0] chm1, input logic [1:0] fw,
                        input logic mono, input logic hold, input logic [7:0] vm);
    cfg_fmt = f; cfg_len = l; cfg_slot24 = s24; cfg_chm1 = chm1; cfg_fsw = fw;
    cfg_mono = mono; cfg_hold = hold; svalid = vm;
  endtask

  // runs nfr whole frames and compares the serial stream against the model
  task automatic run_case(input string tag, input int nfr);
    int tdm, dly, sw, ns, fl, nb, total, idx, rises, bad, p, f, bad_ch;
    logic prev_sck, b;
    logic [31:0] raw, w;
    tdm = int'(cfg_fmt[1]);
    dly = (cfg_fmt[0] == 1'b0) ? 1 : 0;
    sw  = (tdm != 0) ? 32 : pslot(cfg_len, cfg_slot24);
    ns  = (tdm != 0) ? int'(cfg_chm1) + 1 : 2;
    fl  = ns * sw;
    nb  = blen(cfg_len);
    total = nfr * fl;
    for (int k = 0; k < NCH; k++) begin
      exp_ack[k] = 0; exp_unf[k] = 0; got_ack[k] = 0; got_unf[k] = 0;
    end
    for (int fr = 0; fr < nfr; fr++) begin
      for (int s = 0; s < ns; s++) begin
        if (cfg_mono && (s % 2 == 1)) w = wds[fr*8 + s - 1];
        else begin
          if (svalid[s]) begin
            raw = gen(s, mdl_cnt[s]);
            mdl_cnt[s]++;
            mdl_prev[s] = raw;
            exp_ack[s]++;
          end else begin
            raw = cfg_hold ? mdl_prev[s] : 32'h0;
            exp_unf[s]++;
          end
          w = raw << (32 - nb);
        end
        wds[fr*8 + s] = w;
      end
    end
    for (int i = 0; i < total; i++) begin
      p = i % fl;
      f = i / fl;
      if (dly != 0) begin
        if (p == 0) b = (f == 0) ? 1'b0 : bitof(f - 1, fl - 1, sw);
        else        b = bitof(f, p - 1, sw);
      end else b = bitof(f, p, sw);
      exp_sd[i] = b;
      if (tdm == 0) exp_fs[i] = (cfg_fmt == 2'd0) ? (p >= sw) : (p < sw);
      else if (cfg_fsw == 2'd0) exp_fs[i] = (p < 32);
      else if (cfg_fsw == 2'd1) exp_fs[i] = (p < fl / 2);
      else exp_fs[i] = (p == 0);
    end

    @(negedge clk);
    en = 1'b1; tick = 1'b1;
    idx = 0; rises = 0; prev_sck = 1'b0;
    while (idx < total) begin
      @(negedge clk);
      for (int k = 0; k < NCH; k++) begin
        if (ack[k]) begin got_ack[k]++; src_cnt[k]++; end
        if (unf[k]) got_unf[k]++;
      end
      refresh();
      if (sck && !prev_sck) begin
        if (rises > 0) begin
          got_sd[idx] = sd;
          got_fs[idx] = fs;
          idx++;
        end
        rises++;
      end
      prev_sck = sck;
    end
    en = 1'b0; tick = 1'b0;
    @(negedge clk);

    bad = -1;
    for (int i = 0; i < total; i++) if (got_sd[i] !== exp_sd[i] && bad < 0) bad = i;
    check(tag, $sformatf("data stream bit %0d", bad), bad < 0,
          (bad < 0) ? 0 : longint'(got_sd[bad]), (bad < 0) ? 0 : longint'(exp_sd[bad]));
    bad = -1;
    for (int i = 0; i < total; i++) if (got_fs[i] !== exp_fs[i] && bad < 0) bad = i;
    check(tag, $sformatf("frame sync bit %0d", bad), bad < 0,
          (bad < 0) ? 0 : longint'(got_fs[bad]), (bad < 0) ? 0 : longint'(exp_fs[bad]));
    bad_ch = -1;
    for (int k = 0; k < NCH; k++) if (got_ack[k] != exp_ack[k] && bad_ch < 0) bad_ch = k;
    check(tag, $sformatf("accept count ch %0d", bad_ch), bad_ch < 0,
          (bad_ch < 0) ? 0 : got_ack[bad_ch], (bad_ch < 0) ? 0 : exp_ack[bad_ch]);
    bad_ch = -1;
    for (int k = 0; k < NCH; k++) if (got_unf[k] != exp_unf[k] && bad_ch < 0) bad_ch = k;
    check(tag, $sformatf("underrun count ch %0d", bad_ch), bad_ch < 0,
          (bad_ch < 0) ? 0 : got_unf[bad_ch], (bad_ch < 0) ? 0 : exp_unf[bad_ch]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; tick = 1'b1;
    setcfg(2'd0, 3'd0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    for (int k = 0; k < NCH; k++) begin
      src_cnt[k] = 0; mdl_cnt[k] = 0; mdl_prev[k] = 32'h0;
    end
    refresh();
    repeat (4) @(negedge clk);
    // R1
    check("R1", "sck in reset", sck == 1'b0, sck, 0);
    check("R1", "fs in reset", fs == 1'b0, fs, 0);
    check("R1", "sd in reset", sd == 1'b0, sd, 0);
    check("R1", "flags in reset", (ack | unf) == '0, {ack, unf}, 0);
    en = 1'b0; tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_i2s();
    setcfg(2'd0, 3'd0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R2", 2);
    setcfg(2'd0, 3'd2, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R4", 2);
    setcfg(2'd0, 3'd4, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R4", 3);
  endtask

  task automatic t_lj();
    setcfg(2'd1, 3'd0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R3", 2);
    setcfg(2'd1, 3'd6, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R4", 3);
  endtask

  task automatic t_slot24();
    setcfg(2'd1, 3'd1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R5", 2);
    setcfg(2'd0, 3'd3, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R5", 2);
    setcfg(2'd0, 3'd1, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R5", 2);
  endtask

  task automatic t_compact();
    setcfg(2'd1, 3'd5, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R13", 2);
    setcfg(2'd0, 3'd7, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R13", 3);
  endtask

  task automatic t_tdm();
    setcfg(2'd2, 3'd0, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R6", 2);
    setcfg(2'd2, 3'd4, 1'b0, 3'd2, 2'd1, 1'b0, 1'b0, 8'hFF);
    run_case("R7", 2);
    setcfg(2'd2, 3'd1, 1'b0, 3'd3, 2'd2, 1'b0, 1'b0, 8'hFF);
    run_case("R7", 2);
    setcfg(2'd2, 3'd6, 1'b0, 3'd1, 2'd3, 1'b0, 1'b0, 8'hFF);
    run_case("R7", 2);
    setcfg(2'd3, 3'd0, 1'b0, 3'd5, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R8", 2);
  endtask

  task automatic t_mono();
    setcfg(2'd0, 3'd0, 1'b0, 3'd1, 2'd0, 1'b1, 1'b0, 8'hFF);
    run_case("R9", 2);
    setcfg(2'd2, 3'd4, 1'b0, 3'd4, 2'd0, 1'b1, 1'b0, 8'hFF);
    run_case("R9", 2);
  endtask

  task automatic t_underrun();
    setcfg(2'd1, 3'd0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFD);
    run_case("R10", 2);
    setcfg(2'd1, 3'd1, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 8'hFD);
    run_case("R11", 2);
    setcfg(2'd2, 3'd0, 1'b0, 3'd3, 2'd0, 1'b0, 1'b1, 8'hFB);
    run_case("R11", 2);
    // mono with the even channel starved: odd slot must copy the fill word
    setcfg(2'd0, 3'd0, 1'b0, 3'd1, 2'd0, 1'b1, 1'b1, 8'hFE);
    run_case("R9", 2);
  endtask

  task automatic t_ack_pulse();
    int width, maxw, stray;
    setcfg(2'd3, 3'd0, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 8'hFF);
    en = 1'b1; tick = 1'b1;
    width = 0; maxw = 0; stray = 0;
    repeat (200) begin
      @(negedge clk);
      if (ack != '0) begin
        width++;
        if ($countones(ack) != 1 || sck) stray++;
      end else width = 0;
      if (width > maxw) maxw = width;
    end
    en = 1'b0; tick = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) src_cnt[k] = mdl_cnt[k];
    refresh();
    // R12
    check("R12", "accept pulse width", maxw == 1, maxw, 1);
    check("R12", "accept pulse shape", stray == 0, stray, 0);
  endtask

  task automatic t_disable();
    int bad;
    bad = 0;
    en = 1'b0; tick = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (sck || fs || sd) bad++;
    end
    tick = 1'b0;
    // R14
    check("R14", "idle lines while disabled", bad == 0, bad, 0);
    setcfg(2'd1, 3'd4, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 8'hFF);
    run_case("R14", 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s();
    t_lj();
    t_slot24();
    t_compact();
    t_tdm();
    t_mono();
    t_underrun();
    t_ack_pulse();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule